// File: doc/BRIEF.md
# Clock Synthesizer Reconfiguration Register Block

This block is the register front end of a clock synthesizer. Software writes the feedback multiplier, the common input divider, the per-output dividers and the per-output phase values over a simple 32-bit register bus. These writes only change a set of shadow words. The configuration outputs that drive the synthesizer keep their previous values until software writes a start command to a trigger register.

When the start command arrives, every shadow word is copied to the active outputs in a single cycle. In that same cycle the lock indication drops, to model the settling of the loop. Lock returns once a parameterised number of cycles has passed. Software is expected to poll lock before it triggers and again afterwards.

The trigger logic is a three-state machine:
- IDLE: locked, no command pending.
- ARMED: the first half of the two-step command has been seen.
- SETTLE: a reconfiguration has been applied and lock is low.

Its transitions are:
- IDLE to ARMED on an arm write.
- IDLE to SETTLE on the single-write start.
- ARMED to SETTLE on the fire write or the single-write start.
- ARMED back to ARMED on a repeated arm write.
- ARMED to IDLE on any other trigger value.
- SETTLE to IDLE when the settle count runs out.

Top module: `clksyn_cfg_regs`

## Requirements
- R1: After reset, lock is 1 and the active outputs hold the defaults: multiplier 8, fraction 0 with fraction disabled, common divide 1, every output divide 4, every phase 0. The main configuration word reads 0x00000801.
- R2: The main word at byte offset 0x200 holds the common divide in bits 7:0, the integer multiplier in bits 15:8, a 10-bit multiplier fraction in bits 25:16 and a fraction enable in bit 26. Bits 31:27 read 0. A write to it changes only the read-back value and leaves the active outputs unchanged until a trigger.
- R3: Output k has a divider word at 0x208+12*k and a phase word at 0x20C+12*k, with the phase in bits PHASE_W-1:0. Output 0's divider word adds a 10-bit fraction in bits 17:8 and a fraction enable in bit 18. The divider words of the other outputs keep only bits 7:0.
- R4: The status word at offset 0x004 reads lock in bit 0 and 0 in every other bit.
- R5: Writing 0x07 and then 0x02 to the trigger word at 0x25C copies every shadow word to the active outputs. Lock drops at the same clock edge as the copy. The 0x07 write alone changes nothing at the outputs.
- R6: A single write of 0x03 to the trigger word, from IDLE or from ARMED, starts the same reconfiguration.
- R7: A write of 0x02 that does not follow an arm starts nothing. An arm followed by any trigger value other than 0x02, 0x03 or 0x07 cancels the arm.
- R8: After a reconfiguration starts, lock reads 0 for exactly SETTLE_CYCLES cycles and then returns to 1.
- R9: Trigger writes while lock is 0 are ignored: they neither start a second copy nor extend the settle time. Shadow writes in that period still land.
- R10: A divide value of 0, common or per output, is presented on the configuration outputs as 1. The register still reads back 0.
- R11: Unmapped offsets, including 0x204, 0x258, and the trigger word itself, read as 0. Writes to unmapped offsets change neither the read-back values nor the active outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| lock_o | output | 1 | Modelled synthesizer lock |
| mult_o | output | 8 | Active integer feedback multiplier |
| mult_frac_o | output | 10 | Active multiplier fraction |
| mult_frac_en_o | output | 1 | Active multiplier fraction enable |
| cdiv_o | output | 8 | Active common divide, 0 shown as 1 |
| odiv_o | output | NUM_OUT*8 | Active output divides, output k in bits 8k+7:8k, 0 shown as 1 |
| ofrac_o | output | 10 | Active fraction of output 0 |
| ofrac_en_o | output | 1 | Active fraction enable of output 0 |
| phase_o | output | NUM_OUT*PHASE_W | Active phase values, output k in slice k |

## Verification
The hardest situation to reach is a trigger write that lands while lock is low. The design must ignore it, and that can only be seen through timing: the outputs must keep the first copy, and lock must rise exactly on the first command's schedule. The stimulus applies a reconfiguration and then, inside the settle window, rewrites a shadow word. It issues single-write starts, arm writes and fire writes during that window. It then counts cycles to the lock rise and compares the outputs after it.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;
    localparam int OFF_STATUS   = 'h004;
    localparam int OFF_MAIN     = 'h200;
    localparam int OFF_OUT_BASE = 'h208;
    localparam int OUT_STRIDE   = 12;
    localparam int PHASE_GAP    = 4;
    localparam int OFF_TRIGGER  = 'h25C;

    localparam logic [31:0] CMD_ARM    = 32'h07;
    localparam logic [31:0] CMD_FIRE   = 32'h02;
    localparam logic [31:0] CMD_SINGLE = 32'h03;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_SETTLE = 2'd2
    } trig_state_t;

    typedef struct packed {
        logic       frac_en;
        logic [9:0] frac;
        logic [7:0] mult;
        logic [7:0] cdiv;
    } main_cfg_t;
endpackage

// File: rtl/clksyn_trig_fsm.sv
module clksyn_trig_fsm
    import clksyn_pkg::*;
#(
    parameter int SETTLE_CYCLES = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trig_wr,
    input  logic [31:0] trig_val,
    output logic        apply_o,
    output logic        lock_o
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

    trig_state_t state, state_nx;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (apply_o)
                cnt <= CNT_W'(SETTLE_CYCLES - 1);
            else if (state == ST_SETTLE && cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        apply_o  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (trig_wr && trig_val == CMD_SINGLE) begin
                    apply_o  = 1'b1;
                    state_nx = ST_SETTLE;
                end else if (trig_wr && trig_val == CMD_ARM) begin
                    state_nx = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (trig_wr) begin
                    if (trig_val == CMD_FIRE || trig_val == CMD_SINGLE) begin
                        apply_o  = 1'b1;
                        state_nx = ST_SETTLE;
                    end else if (trig_val != CMD_ARM) begin
                        state_nx = ST_IDLE;
                    end
                end
            end
            ST_SETTLE: begin
                if (cnt == '0)
                    state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
        lock_o = (state != ST_SETTLE);
    end

    // R5: lock only falls on the edge that follows a start
    assert_lock_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_o) |-> $past(apply_o));
    // R9: no start is issued while lock is low
    assert_no_start_unlocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_o |-> !apply_o);
    // R8: the last settle cycle is followed by lock
    assert_relock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE && cnt == '0) |=> lock_o);
    // R8: the settle count never exceeds its window
    assert_cnt_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_o |-> cnt < CNT_W'(SETTLE_CYCLES));
endmodule

// File: rtl/clksyn_shadow_bank.sv
module clksyn_shadow_bank
    import clksyn_pkg::*;
#(
    parameter int NUM_OUT  = 7,
    parameter int PHASE_W  = 16,
    parameter int ADDR_W   = 12,
    parameter int DEF_MULT = 8,
    parameter int DEF_CDIV = 1,
    parameter int DEF_ODIV = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [31:0]                wdata,
    input  logic                       apply,
    output logic [31:0]                rd_data,
    output main_cfg_t                  act_main,
    output logic [NUM_OUT*8-1:0]       act_odiv,
    output logic [9:0]                 act_ofrac,
    output logic                       act_ofrac_en,
    output logic [NUM_OUT*PHASE_W-1:0] act_phase
);
    localparam int MAIN_W = $bits(main_cfg_t);

    main_cfg_t          sh_main;
    logic [7:0]         sh_odiv  [NUM_OUT];
    logic [PHASE_W-1:0] sh_phase [NUM_OUT];
    logic [9:0]         sh_ofrac;
    logic               sh_ofrac_en;
    logic [7:0]         ac_odiv  [NUM_OUT];
    logic [PHASE_W-1:0] ac_phase [NUM_OUT];

    function automatic logic div_hit(input logic [ADDR_W-1:0] a, input int k);
        return a == ADDR_W'(OFF_OUT_BASE + OUT_STRIDE * k);
    endfunction
    function automatic logic ph_hit(input logic [ADDR_W-1:0] a, input int k);
        return a == ADDR_W'(OFF_OUT_BASE + OUT_STRIDE * k + PHASE_GAP);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_main      <= '{frac_en: 1'b0, frac: '0, mult: 8'(DEF_MULT), cdiv: 8'(DEF_CDIV)};
            act_main     <= '{frac_en: 1'b0, frac: '0, mult: 8'(DEF_MULT), cdiv: 8'(DEF_CDIV)};
            sh_ofrac     <= '0;
            sh_ofrac_en  <= 1'b0;
            act_ofrac    <= '0;
            act_ofrac_en <= 1'b0;
            for (int k = 0; k < NUM_OUT; k++) begin
                sh_odiv[k]  <= 8'(DEF_ODIV);
                ac_odiv[k]  <= 8'(DEF_ODIV);
                sh_phase[k] <= '0;
                ac_phase[k] <= '0;
            end
        end else begin
            if (apply) begin
                act_main     <= sh_main;
                act_ofrac    <= sh_ofrac;
                act_ofrac_en <= sh_ofrac_en;
                for (int k = 0; k < NUM_OUT; k++) begin
                    ac_odiv[k]  <= sh_odiv[k];
                    ac_phase[k] <= sh_phase[k];
                end
            end
            if (wr_en) begin
                if (addr == ADDR_W'(OFF_MAIN))
                    sh_main <= wdata[MAIN_W-1:0];
                for (int k = 0; k < NUM_OUT; k++) begin
                    if (div_hit(addr, k)) begin
                        sh_odiv[k] <= wdata[7:0];
                        if (k == 0) begin
                            sh_ofrac    <= wdata[17:8];
                            sh_ofrac_en <= wdata[18];
                        end
                    end
                    if (ph_hit(addr, k))
                        sh_phase[k] <= wdata[PHASE_W-1:0];
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == ADDR_W'(OFF_MAIN))
            rd_data = 32'(sh_main);
        for (int k = 0; k < NUM_OUT; k++) begin
            if (div_hit(addr, k)) begin
                rd_data = {24'd0, sh_odiv[k]};
                if (k == 0)
                    rd_data = {13'd0, sh_ofrac_en, sh_ofrac, sh_odiv[0]};
            end
            if (ph_hit(addr, k))
                rd_data = 32'(sh_phase[k]);
        end
    end

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_flat
        assign act_odiv[g*8 +: 8]            = ac_odiv[g];
        assign act_phase[g*PHASE_W +: PHASE_W] = ac_phase[g];
    end

    // R2: active configuration only moves on a start
    assert_active_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(act_main) && $stable(act_odiv) && $stable(act_phase));
endmodule

// File: rtl/clksyn_cfg_regs.sv
module clksyn_cfg_regs
    import clksyn_pkg::*;
#(
    parameter int NUM_OUT       = 7,
    parameter int PHASE_W       = 16,
    parameter int ADDR_W        = 12,
    parameter int SETTLE_CYCLES = 64,
    parameter int DEF_MULT      = 8,
    parameter int DEF_CDIV      = 1,
    parameter int DEF_ODIV      = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr_en,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    output logic                       lock_o,
    output logic [7:0]                 mult_o,
    output logic [9:0]                 mult_frac_o,
    output logic                       mult_frac_en_o,
    output logic [7:0]                 cdiv_o,
    output logic [NUM_OUT*8-1:0]       odiv_o,
    output logic [9:0]                 ofrac_o,
    output logic                       ofrac_en_o,
    output logic [NUM_OUT*PHASE_W-1:0] phase_o
);
    logic                 trig_wr, apply, status_sel;
    logic [31:0]          bank_rdata;
    main_cfg_t            act_main;
    logic [NUM_OUT*8-1:0] act_odiv;

    assign trig_wr    = bus_wr_en && bus_addr == ADDR_W'(OFF_TRIGGER);
    assign status_sel = bus_addr == ADDR_W'(OFF_STATUS);

    clksyn_trig_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .trig_wr(trig_wr), .trig_val(bus_wdata),
        .apply_o(apply), .lock_o(lock_o)
    );

    clksyn_shadow_bank #(
        .NUM_OUT(NUM_OUT), .PHASE_W(PHASE_W), .ADDR_W(ADDR_W),
        .DEF_MULT(DEF_MULT), .DEF_CDIV(DEF_CDIV), .DEF_ODIV(DEF_ODIV)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
        .wdata(bus_wdata), .apply(apply), .rd_data(bank_rdata),
        .act_main(act_main), .act_odiv(act_odiv), .act_ofrac(ofrac_o),
        .act_ofrac_en(ofrac_en_o), .act_phase(phase_o)
    );

    assign bus_rdata      = status_sel ? {31'd0, lock_o} : bank_rdata;
    assign mult_o         = act_main.mult;
    assign mult_frac_o    = act_main.frac;
    assign mult_frac_en_o = act_main.frac_en;
    assign cdiv_o         = (act_main.cdiv == 8'd0) ? 8'd1 : act_main.cdiv;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_div
        assign odiv_o[g*8 +: 8] = (act_odiv[g*8 +: 8] == 8'd0) ? 8'd1 : act_odiv[g*8 +: 8];
    end

    // R4: status word mirrors lock
    assert_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status_sel |-> bus_rdata == {31'd0, lock_o});
    // R11: the trigger word is write-only
    assert_trig_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == ADDR_W'(OFF_TRIGGER) |-> bus_rdata == 32'd0);
    // R10: presented divides are never zero
    assert_div_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cdiv_o != 8'd0);
endmodule

// File: tb/test_clksyn_cfg_regs.sv
module test_clksyn_cfg_regs;
    localparam int CLK_PERIOD = 10;
    localparam int NOUT = 7;
    localparam int PW   = 16;
    localparam int AW   = 12;
    localparam int SET  = 64;

    logic clk = 0, rst_n = 0, bus_wr_en = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic lock_o, mult_frac_en_o, ofrac_en_o;
    logic [7:0] mult_o, cdiv_o;
    logic [9:0] mult_frac_o, ofrac_o;
    logic [NOUT*8-1:0] odiv_o;
    logic [NOUT*PW-1:0] phase_o;

    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clksyn_cfg_regs #(.NUM_OUT(NOUT), .PHASE_W(PW), .ADDR_W(AW), .SETTLE_CYCLES(SET)) i_clksyn_cfg_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_o(lock_o),
        .mult_o(mult_o), .mult_frac_o(mult_frac_o), .mult_frac_en_o(mult_frac_en_o),
        .cdiv_o(cdiv_o), .odiv_o(odiv_o), .ofrac_o(ofrac_o), .ofrac_en_o(ofrac_en_o),
        .phase_o(phase_o)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr_en = 1;
        @(posedge clk);
        #1 bus_wr_en = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a);
        #1 d = bus_rdata;
    endtask

    task automatic wait_lock();
        for (int i = 0; i < 4*SET && !lock_o; i++) @(negedge clk);
    endtask

    function automatic int div_off(input int k); return 'h208 + 12*k; endfunction

    task automatic t_reset();
        logic [31:0] d;
        #1;
        check(lock_o === 1'b1, "R1 lock", 32'(lock_o), 1);
        check(mult_o == 8 && cdiv_o == 1 && !mult_frac_en_o, "R1 main", {mult_o, cdiv_o}, 32'h0801);
        for (int k = 0; k < NOUT; k++)
            check(odiv_o[k*8 +: 8] == 4 && phase_o[k*PW +: PW] == 0, "R1 out", 32'(odiv_o[k*8 +: 8]), 4);
        rd('h200, d); check(d == 32'h801, "R1 word0", d, 32'h801);
        rd('h004, d); check(d == 32'h1, "R4 status", d, 1);
    endtask

    task automatic t_shadow();
        logic [31:0] d, v;
        v = (32'd1 << 26) | (32'd500 << 16) | (32'd12 << 8) | 32'd2;
        wr('h200, v | 32'hF800_0000);
        rd('h200, d); check(d == v, "R2 readback", d, v);
        check(mult_o == 8 && cdiv_o == 1, "R2 active unchanged", 32'(mult_o), 8);
    endtask

    task automatic t_outputs();
        logic [31:0] d;
        wr(div_off(2), 32'hFFFF_FF05);
        rd(div_off(2), d); check(d == 32'h05, "R3 out2 div", d, 5);
        wr(div_off(0), 32'hFFF8_0000 | (32'd1 << 18) | (32'd250 << 8) | 32'd3);
        rd(div_off(0), d); check(d == ((32'd1 << 18) | (32'd250 << 8) | 3), "R3 out0 frac", d, 32'h4FA03);
        wr(div_off(3) + 4, 32'hABCD_1234);
        rd(div_off(3) + 4, d); check(d == 32'h1234, "R3 out3 phase", d, 32'h1234);
    endtask

    task automatic t_two_step();
        wr('h25C, 32'h07);
        check(lock_o && mult_o == 8, "R5 arm alone", {lock_o, mult_o}, 32'h108);
        wr('h25C, 32'h02);
        check(!lock_o, "R5 lock drop", 32'(lock_o), 0);
        check(mult_o == 12 && cdiv_o == 2 && mult_frac_o == 500 && mult_frac_en_o, "R5 main copy", 32'(mult_o), 12);
        check(odiv_o[2*8 +: 8] == 5 && odiv_o[0 +: 8] == 3 && ofrac_o == 250 && ofrac_en_o, "R5 out copy", 32'(odiv_o[23:16]), 5);
        check(phase_o[3*PW +: PW] == 16'h1234, "R5 phase copy", 32'(phase_o[3*PW +: PW]), 32'h1234);
        for (int i = 0; i < SET - 1; i++) @(posedge clk);
        #1 check(!lock_o, "R8 still low", 32'(lock_o), 0);
        @(posedge clk); #1 check(lock_o, "R8 relock", 32'(lock_o), 1);
    endtask

    task automatic t_settle_ignore();
        logic [31:0] d;
        wr('h200, 32'(20 << 8) | 1);
        wr('h25C, 32'h03);
        wr('h200, 32'(40 << 8) | 1);
        wr('h25C, 32'h03);
        wr('h25C, 32'h07);
        wr('h25C, 32'h02);
        for (int i = 0; i < SET - 5; i++) @(posedge clk);
        #1 check(!lock_o, "R9 window not extended low", 32'(lock_o), 0);
        @(posedge clk); #1 check(lock_o, "R9 window not extended", 32'(lock_o), 1);
        check(mult_o == 20, "R9 no second copy", 32'(mult_o), 20);
        rd('h200, d); check(d[15:8] == 40, "R9 shadow landed", 32'(d[15:8]), 40);
    endtask

    task automatic t_single();
        wr('h25C, 32'h03);
        check(!lock_o && mult_o == 40, "R6 single start", {lock_o, mult_o}, 40);
        wait_lock();
        wr('h200, 32'(44 << 8) | 1);
        wr('h25C, 32'h07);
        wr('h25C, 32'h03);
        check(!lock_o && mult_o == 44, "R6 single from armed", {lock_o, mult_o}, 44);
        wait_lock();
    endtask

    task automatic t_disarm();
        wr('h200, 32'(30 << 8) | 1);
        wr('h25C, 32'h02);
        check(lock_o && mult_o == 44, "R7 fire without arm", {lock_o, mult_o}, 32'h12C);
        wr('h25C, 32'h07);
        wr('h25C, 32'h05);
        wr('h25C, 32'h02);
        check(lock_o && mult_o == 44, "R7 arm cancelled", {lock_o, mult_o}, 32'h12C);
    endtask

    task automatic t_zero();
        logic [31:0] d;
        wr('h200, 32'(30 << 8));
        wr(div_off(1), 32'h0);
        wr('h25C, 32'h03);
        check(cdiv_o == 1 && odiv_o[8 +: 8] == 1, "R10 zero as one", {cdiv_o, odiv_o[15:8]}, 32'h0101);
        rd('h200, d); check(d[7:0] == 0, "R10 readback zero", 32'(d[7:0]), 0);
        wait_lock();
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr('h204, 32'hFFFF_FFFF);
        wr('h258, 32'hFFFF_FFFF);
        wr('h100, 32'hFFFF_FFFF);
        rd('h204, d); check(d == 0, "R11 0x204", d, 0);
        rd('h258, d); check(d == 0, "R11 0x258", d, 0);
        rd('h100, d); check(d == 0, "R11 0x100", d, 0);
        rd('h25C, d); check(d == 0, "R11 trigger reads zero", d, 0);
        rd('h200, d); check(d == 32'(30 << 8), "R11 word0 intact", d, 32'(30 << 8));
        check(lock_o && mult_o == 30 && odiv_o[8 +: 8] == 1, "R11 outputs intact", 32'(mult_o), 30);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_shadow();
        t_outputs();
        t_two_step();
        t_settle_ignore();
        t_single();
        t_disarm();
        t_zero();
        t_unmapped();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule